// File: doc/BRIEF.md
# Banked Memory Access Controller

This block puts a set of independent single-port storage banks behind one request port. Each cycle it can accept one read or write and steer it to the bank chosen by the address. A bank stays occupied for a fixed number of cycles once it takes an access. During that time the controller accepts requests that go to other banks, so accesses overlap. A request whose bank is still occupied is held off through a ready/valid handshake until that bank frees up. Read data come back in issue order, with one valid pulse per read.

A one-bit mode input picks how addresses are spread across the banks:
- **Interleaved mode:** the low address bits select the bank, so consecutive words fall in consecutive banks.
- **Block mode:** the high address bits select the bank, so each bank holds one contiguous range.

The mode is expected to change only while every bank is idle. The bank count and the words per bank must both be powers of two, with at least two banks. Addresses are word addresses.

Top module: `mbank_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `rsp_valid` is 0 and `req_ready` is 1 for every address.
- R2: With `map_block` = 0, address A maps to bank A mod NUM_BANKS and word A / NUM_BANKS. With 4 banks, addresses 5 and 9 share bank 1, and 5 and 6 do not share a bank.
- R3: With `map_block` = 1, address A maps to bank A / BANK_WORDS and word A mod BANK_WORDS. With 256 words per bank, addresses 0 and 1 share bank 0, and 0, 256, 512 and 768 fall in banks 0 to 3.
- R4: A bank that accepts a request at a clock edge refuses further requests for the next BANK_LAT-1 cycles. A second request to it, held valid, sees `req_ready` low for exactly BANK_LAT-1 cycles.
- R5: Requests to banks that are not occupied are accepted on consecutive cycles, with `req_ready` high, even while other banks are occupied.
- R6: A read returns the value most recently written to the same address under the same mapping mode.
- R7: A read accepted at clock edge e produces `rsp_valid` high for exactly one cycle, registered at edge e+BANK_LAT. Responses appear in the order the reads were accepted.
- R8: A write occupies its bank like a read but never raises `rsp_valid`.
- R9: In interleaved mode with BANK_LAT no greater than NUM_BANKS, a stream whose stride is coprime with NUM_BANKS runs without a stall. A stride equal to NUM_BANKS stalls BANK_LAT-1 cycles on every request after the first.
- R10: While `req_valid` is 0, nothing is accepted: no bank becomes occupied and no response is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| map_block | input | 1 | 0 = interleaved mapping, 1 = block mapping |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Target bank free; request accepted when both are high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (10) | Word address |
| req_wdata | input | DATA_W (16) | Write data |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | DATA_W (16) | Read data, valid with rsp_valid |

## Verification
The bench goes after several corner cases:
- **Same-bank pairs in each mode.** If the bank were chosen from the wrong address bits, the pair 5/9 would not stall in interleaved mode, or 0/1 would not stall in block mode.
- **Stall length.** A busy counter that is off by one gives BANK_LAT-2 or BANK_LAT stall cycles instead of BANK_LAT-1.
- **Stream strides.** Coprime strides must show no stall at all, and a stride of NUM_BANKS must stall on every request. This catches a controller that serialises all traffic, or one that lets a busy bank accept.
- **Response timing and order.** Read-back after writes in both modes checks the word slicing. Comparing `rsp_valid` and the data every cycle exposes a response one cycle early or late, a response raised for a write, or data taken from the wrong bank.

// File: rtl/mbank_pkg.sv
// Shared definitions for the banked memory controller.
// Assumes: nothing beyond IEEE 1800-2017.
package mbank_pkg;

    // Address spreading modes, encoded as the map_block pin value
    typedef enum logic {
        MAP_INTERLEAVE = 1'b0,
        MAP_BLOCK      = 1'b1
    } map_mode_e;

endpackage

// File: rtl/mbank_map.sv
// Address-to-bank mapper.
// Splits a word address into bank index and word-in-bank index. Interleaved
// mode takes the bank from the low bits; block mode takes it from the high bits.
// Assumes: NUM_BANKS and BANK_WORDS are powers of two, NUM_BANKS >= 2.
module mbank_map
    import mbank_pkg::*;
#(
    parameter  int NUM_BANKS  = 4,
    parameter  int BANK_WORDS = 256,
    localparam int BSEL_W     = $clog2(NUM_BANKS),
    localparam int WSEL_W     = $clog2(BANK_WORDS),
    localparam int ADDR_W     = BSEL_W + WSEL_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  map_mode_e         mode,
    output logic [BSEL_W-1:0] bank,
    output logic [WSEL_W-1:0] word
);

    // Pick bank and word slices according to the mapping mode
    always_comb begin
        if (mode == MAP_BLOCK) begin
            bank = addr[ADDR_W-1:WSEL_W];
            word = addr[WSEL_W-1:0];
        end else begin
            bank = addr[BSEL_W-1:0];
            word = addr[ADDR_W-1:BSEL_W];
        end
    end

endmodule

// File: rtl/mbank_unit.sv
// One storage bank with its occupancy counter.
// Takes an access when selected and idle, then reports busy for BANK_LAT-1
// further cycles. Write data land in storage at acceptance. Read data are
// captured into a hold register at acceptance and presented until the next read.
// Assumes: BANK_LAT >= 2; the caller only selects the bank with a live request.
module mbank_unit #(
    parameter  int BANK_WORDS = 256,
    parameter  int DATA_W     = 16,
    parameter  int BANK_LAT   = 3,
    localparam int WSEL_W     = $clog2(BANK_WORDS),
    localparam int CNT_W      = $clog2(BANK_LAT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              we,
    input  logic [WSEL_W-1:0] word,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              acc,
    output logic [DATA_W-1:0] hold
);

    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BANK_LAT - 1);

    logic [CNT_W-1:0]  occ_cnt;
    logic [DATA_W-1:0] store [BANK_WORDS];

    assign busy = (occ_cnt != '0);
    assign acc  = sel && !busy;

    // Occupancy counter: load on accept, count down to idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_cnt <= '0;
        end else if (acc) begin
            occ_cnt <= CNT_LOAD;
        end else if (busy) begin
            occ_cnt <= occ_cnt - 1'b1;
        end
    end

    // Storage array write port
    always_ff @(posedge clk) begin
        if (acc && we) begin
            store[word] <= wdata;
        end
    end

    // Read capture into the hold register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= '0;
        end else if (acc && !we) begin
            hold <= store[word];
        end
    end

    // R4
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> busy);

    // R4
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !acc);

endmodule

// File: rtl/mbank_rsp_pipe.sv
// In-order read response pipeline.
// Carries a tag (valid flag and bank index) for every accepted read through
// BANK_LAT stages. When a tag leaves the last stage, its bank's hold data are
// registered onto the response port. The latency is fixed and at most one read
// is accepted per cycle, so tag order is issue order.
// Assumes: a bank's hold register is not overwritten before its tag leaves.
module mbank_rsp_pipe #(
    parameter  int NUM_BANKS = 4,
    parameter  int DATA_W    = 16,
    parameter  int BANK_LAT  = 3,
    localparam int BSEL_W    = $clog2(NUM_BANKS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              push,
    input  logic [BSEL_W-1:0]                 push_bank,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0]  hold_vec,
    output logic                              rsp_valid,
    output logic [DATA_W-1:0]                 rsp_rdata
);

    logic [BANK_LAT-1:0] tag_vld;
    logic [BSEL_W-1:0]   tag_bank [BANK_LAT];

    // First stage takes the tag of the read accepted this cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_vld[0]  <= 1'b0;
            tag_bank[0] <= '0;
        end else begin
            tag_vld[0]  <= push;
            tag_bank[0] <= push_bank;
        end
    end

    // Remaining stages shift the tags one step per cycle
    for (genvar s = 1; s < BANK_LAT; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_vld[s]  <= 1'b0;
                tag_bank[s] <= '0;
            end else begin
                tag_vld[s]  <= tag_vld[s-1];
                tag_bank[s] <= tag_bank[s-1];
            end
        end
    end

    // Output register: strobe and data of the oldest tag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= tag_vld[BANK_LAT-1];
            if (tag_vld[BANK_LAT-1]) begin
                rsp_rdata <= hold_vec[tag_bank[BANK_LAT-1]];
            end
        end
    end

    // R1
    rsp_quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !rsp_valid);

endmodule

// File: rtl/mbank_ctrl.sv
// Banked memory access controller, top level.
// Maps each request to a bank, raises ready only when that bank is idle, and
// starts the access on valid and ready. It returns read data in order through
// the response pipeline.
// Assumes: map_block changes only while all banks are idle.
module mbank_ctrl
    import mbank_pkg::*;
#(
    parameter  int NUM_BANKS  = 4,
    parameter  int BANK_WORDS = 256,
    parameter  int DATA_W     = 16,
    parameter  int BANK_LAT   = 3,
    localparam int BSEL_W     = $clog2(NUM_BANKS),
    localparam int WSEL_W     = $clog2(BANK_WORDS),
    localparam int ADDR_W     = BSEL_W + WSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_block,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic [BSEL_W-1:0]                tgt_bank;
    logic [WSEL_W-1:0]                tgt_word;
    logic [NUM_BANKS-1:0]             busy_vec;
    logic [NUM_BANKS-1:0]             acc_vec;
    logic [NUM_BANKS-1:0]             sel_vec;
    logic [NUM_BANKS-1:0][DATA_W-1:0] hold_vec;
    logic                             rd_push;

    mbank_map #(
        .NUM_BANKS  (NUM_BANKS),
        .BANK_WORDS (BANK_WORDS)
    ) u_map (
        .addr (req_addr),
        .mode (map_mode_e'(map_block)),
        .bank (tgt_bank),
        .word (tgt_word)
    );

    // Decode the live request onto a one-hot bank select
    always_comb begin
        sel_vec = '0;
        sel_vec[tgt_bank] = req_valid;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        mbank_unit #(
            .BANK_WORDS (BANK_WORDS),
            .DATA_W     (DATA_W),
            .BANK_LAT   (BANK_LAT)
        ) u_unit (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (sel_vec[b]),
            .we    (req_write),
            .word  (tgt_word),
            .wdata (req_wdata),
            .busy  (busy_vec[b]),
            .acc   (acc_vec[b]),
            .hold  (hold_vec[b])
        );
    end

    // Ready follows the occupancy of the addressed bank
    assign req_ready = !busy_vec[tgt_bank];
    assign rd_push   = (acc_vec != '0) && !req_write;

    mbank_rsp_pipe #(
        .NUM_BANKS (NUM_BANKS),
        .DATA_W    (DATA_W),
        .BANK_LAT  (BANK_LAT)
    ) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rd_push),
        .push_bank (tgt_bank),
        .hold_vec  (hold_vec),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // R5
    single_bank_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acc_vec));

    // R10
    idle_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (acc_vec == '0));

endmodule

// File: tb/mbank_ctrl_bench.sv
// Self-checking bench with a behavioural cycle model (queues and integers).
module mbank_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NB   = 4;
    localparam int BW   = 256;
    localparam int DW   = 16;
    localparam int LAT  = 3;
    localparam int AW   = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          map_block = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;

    mbank_ctrl #(
        .NUM_BANKS (NB), .BANK_WORDS (BW), .DATA_W (DW), .BANK_LAT (LAT)
    ) u_mbank_ctrl (
        .clk (clk), .rst_n (rst_n), .map_block (map_block),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // model state
    int busy_m [NB];
    int mem_m  [NB][BW];
    int due_q  [$];
    int dat_q  [$];
    int cyc = 0;
    int checks = 0;
    int fails  = 0;
    int rsp_seen = 0;
    bit done = 0;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    function automatic int bank_of(int a);
        return map_block ? a / BW : a % NB;
    endfunction

    function automatic int word_of(int a);
        return map_block ? a % BW : a / NB;
    endfunction

    // one cycle: drive at negedge, compare ready, advance model at posedge, compare response
    task automatic step(bit v, bit w, int a, int d, string tag, output bit acc);
        bit exp_rdy;
        bit exp_v;
        req_valid = v; req_write = w; req_addr = AW'(a); req_wdata = DW'(d);
        #1;
        exp_rdy = (busy_m[bank_of(a)] == 0);
        chk(req_ready == exp_rdy, tag, "req_ready", int'(req_ready), int'(exp_rdy));
        acc = v && exp_rdy;
        @(posedge clk);
        cyc++;
        for (int b = 0; b < NB; b++) if (busy_m[b] > 0) busy_m[b]--;
        if (acc) begin
            busy_m[bank_of(a)] = LAT - 1;
            if (w) mem_m[bank_of(a)][word_of(a)] = d & 16'hFFFF;
            else begin
                due_q.push_back(cyc + LAT);
                dat_q.push_back(mem_m[bank_of(a)][word_of(a)]);
            end
        end
        @(negedge clk);
        exp_v = (due_q.size() > 0) && (due_q[0] == cyc);
        if (rsp_valid) rsp_seen++;
        chk(rsp_valid == exp_v, "R7", "rsp_valid", int'(rsp_valid), int'(exp_v));
        if (exp_v) begin
            chk(int'(rsp_rdata) == dat_q[0], "R6", "rsp_rdata", int'(rsp_rdata), dat_q[0]);
            void'(due_q.pop_front());
            void'(dat_q.pop_front());
        end
    endtask

    // hold one request until accepted, returning the stall count
    task automatic issue(bit w, int a, int d, string tag, output int stalls);
        bit acc;
        stalls = 0;
        acc = 0;
        while (!acc) begin
            step(1'b1, w, a, d, tag, acc);
            if (!acc) stalls++;
        end
        req_valid = 1'b0;
    endtask

    task automatic idle(int n);
        bit acc;
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, 0, "R10", acc);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int st;
        int tot;
        int seen0;
        bit acc;
        for (int b = 0; b < NB; b++) begin
            busy_m[b] = 0;
            for (int w = 0; w < BW; w++) mem_m[b][w] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);
        @(negedge clk);

        // R5 / R9: stride-1 writes in interleaved mode never stall
        tot = 0;
        for (int i = 0; i < 16; i++) begin
            issue(1'b1, i, 16'h1000 + i * 7, "R5", st);
            tot += st;
        end
        chk(tot == 0, "R5", "stalls on stride-1 writes", tot, 0);
        // R8: writes give no response
        seen0 = rsp_seen;
        idle(LAT + 1);
        chk(rsp_seen == seen0, "R8", "responses after writes", rsp_seen - seen0, 0);

        // R6 / R7: read back in order
        for (int i = 0; i < 16; i++) issue(1'b0, i, 0, "R6", st);
        idle(LAT + 1);

        // R4: same bank back to back
        issue(1'b1, 0, 16'hBEEF, "R4", st);
        issue(1'b1, 4, 16'h0C0C, "R4", st);
        chk(st == LAT - 1, "R4", "stall cycles same bank", st, LAT - 1);
        idle(LAT);

        // R2: interleaved mapping, 5/9 share bank 1, 5/6 do not
        issue(1'b0, 5, 0, "R2", st);
        issue(1'b0, 9, 0, "R2", st);
        chk(st == LAT - 1, "R2", "stall 5 then 9", st, LAT - 1);
        idle(LAT);
        issue(1'b0, 5, 0, "R2", st);
        issue(1'b0, 6, 0, "R2", st);
        chk(st == 0, "R2", "stall 5 then 6", st, 0);
        idle(LAT + 1);

        // R9: stride 3 coprime, no stall; stride 4 stalls each time
        tot = 0;
        for (int i = 0; i < 12; i++) begin
            issue(1'b0, (i * 3) % 16, 0, "R9", st);
            tot += st;
        end
        chk(tot == 0, "R9", "stalls stride 3", tot, 0);
        idle(LAT + 1);
        tot = 0;
        for (int i = 0; i < 4; i++) begin
            issue(1'b0, i * 4, 0, "R9", st);
            tot += st;
        end
        chk(tot == 3 * (LAT - 1), "R9", "stalls stride 4", tot, 3 * (LAT - 1));
        idle(LAT + 1);

        // R10: valid low on a bank's address keeps it free
        for (int i = 0; i < LAT; i++) step(1'b0, 1'b1, 8, 16'hDEAD, "R10", acc);
        issue(1'b0, 8, 0, "R10", st);
        chk(st == 0, "R10", "stall after idle valid-low cycles", st, 0);
        idle(LAT + 1);

        // R3: block mapping
        map_block = 1'b1;
        tot = 0;
        for (int i = 0; i < NB; i++) begin
            issue(1'b1, i * BW, 16'h2200 + i, "R3", st);
            tot += st;
        end
        chk(tot == 0, "R3", "stalls 0/256/512/768", tot, 0);
        idle(LAT);
        issue(1'b1, 0, 16'h3300, "R3", st);
        issue(1'b1, 1, 16'h3301, "R3", st);
        chk(st == LAT - 1, "R3", "stall 0 then 1", st, LAT - 1);
        for (int i = 0; i < NB; i++) issue(1'b0, i * BW + 1, 0, "R6", st);
        for (int i = 0; i < NB; i++) issue(1'b0, i * BW, 0, "R6", st);
        seen0 = rsp_seen;
        issue(1'b0, 700, 0, "R7", st);
        idle(LAT + 2);
        chk(rsp_seen - seen0 >= 1, "R7", "response to final read", rsp_seen - seen0, 1);
        chk(due_q.size() == 0, "R7", "pending responses", due_q.size(), 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule